// File: doc/BRIEF.md
# Oversampling Serial Receiver Front End

This block recovers bytes from an asynchronous serial line. It samples the line once per sample tick, and the tick runs at sixteen times the bit rate. A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. The block finds a candidate start edge and checks it against noise. It takes a majority vote over three samples in the middle of every bit. It also realigns its sample counter on high-to-low data transitions, so that a sender whose bit rate is somewhat off is still received correctly.

When a frame ends, the received byte goes into a holding register and a ready flag is raised. A noise flag and a framing-error flag are raised alongside it when needed. All three flags stay set until the consumer pulses a one-cycle clear. An interrupt request follows the ready flag while the interrupt enable input is high. The byte leaves the block as plain status and has no valid/ready handshake. The consumer cannot apply back-pressure: a new frame overwrites the holding register whether or not the old byte was read. The clear pulse acknowledges the byte. If a clear arrives in the same cycle that a frame completes, the completing frame wins, and the flags then show only the new frame's results.

Top module: `serial_rx_recover`

## Requirements
- R1: The line is sampled only on cycles where `rt_tick` is high. A line value reaches the sampler two clock cycles after it appears on `rxd`. Line activity while `rt_tick` stays low starts no frame.
- R2: A frame starts on a low sample whose three preceding tick samples were all high. That low sample is sample position 1 of the start bit, and positions count from 1 to 16 in every bit.
- R3: The start bit is judged on its samples at positions 3, 5 and 7. If at least two of them are low, the frame continues. Otherwise it is abandoned, no flag changes, and a new start needs three fresh high samples followed by a low one.
- R4: An accepted start bit whose position 3, 5 and 7 samples are not all low sets the noise flag when the frame completes.
- R5: Each data bit takes the majority of its samples at positions 8, 9 and 10. The bits fill `rx_byte` from bit 0 upward.
- R6: When the position 8, 9 and 10 samples of any data bit or of the stop bit disagree, the noise flag is set when the frame completes.
- R7: A stop bit whose majority is low sets `rx_frame_err`. The byte is still delivered and `rx_full` is still set.
- R8: After a data bit with majority high, a high-to-low sample pair seen at positions 1 to 7 of the next bit restarts that bit's count at position 1. This keeps 17-tick bits aligned.
- R9: After a data bit with majority high, a high-to-low sample pair seen at positions 11 to 16 of the same bit ends that bit early and becomes position 1 of the next bit. This keeps 15-tick bits aligned.
- R10: `rx_full`, `rx_noise` and `rx_frame_err` are set at frame completion and stay set until `flag_clr` is pulsed. A clear leaves `rx_byte` unchanged.
- R11: `rx_irq` is high exactly when `rx_full` and `rx_int_en` are both high.
- R12: The stop bit's three vote samples count as idle history. A start bit that directly follows a 16-tick stop bit is therefore received.
- R13: After reset the receiver searches for a start bit, all flags and `rx_irq` are low, and `rx_byte` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rt_tick | input | 1 | Sample enable at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| flag_clr | input | 1 | One-cycle pulse that clears the three flags |
| rx_int_en | input | 1 | Receive interrupt enable |
| rx_byte | output | 8 | Byte of the last completed frame |
| rx_full | output | 1 | A completed byte is waiting |
| rx_noise | output | 1 | Noise was seen in a completed frame |
| rx_frame_err | output | 1 | A completed frame had a low stop bit |
| rx_irq | output | 1 | Interrupt request |

## Verification
A line value reaches the sampler two clocks after it is driven. The flags and `rx_byte` change on the clock edge of the tick that carries the stop bit's position 10 sample, and `rx_irq` follows `rx_full` in the same cycle. The bench drives exactly one line value per tick and raises each tick three clocks into its slot, so the synchronizer delay never straddles a sample. It reads the outputs at falling clock edges, and only after every slot of the frame, including any trailing idle slots, has been driven, which is well past the edge where the results are due. The effect of a clear is read two falling edges after the pulse.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic agree3(input logic a, input logic b, input logic c);
    return (a == b) && (b == c);
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_sampler.sv
module rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  output logic       start_ok,
  output logic       start_noise,
  output logic       bit_stb,
  output logic       bit_val,
  output logic       bit_noise,
  output logic       stop_stb,
  output logic       stop_val,
  output logic       stop_noise,
  output logic [$clog2(OSR+1)-1:0] cnt_o,
  output logic [1:0] state_o
);
  localparam int CW = $clog2(OSR + 1);
  localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] P_ONE  = CW'(1);
  localparam logic [CW-1:0] P_LAST = CW'(OSR);
  localparam logic [CW-1:0] P_V1   = CW'((3 * OSR) / 16);
  localparam logic [CW-1:0] P_V2   = CW'((5 * OSR) / 16);
  localparam logic [CW-1:0] P_V3   = CW'((7 * OSR) / 16);
  localparam logic [CW-1:0] P_M1   = CW'(OSR / 2);
  localparam logic [CW-1:0] P_M2   = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] P_M3   = CW'(OSR / 2 + 2);
  localparam logic [CW-1:0] P_EARLY = CW'(OSR / 2 + 3);
  localparam logic [IW-1:0] IDX_LAST = IW'(DATA_BITS - 1);

  rx_state_e        state;
  logic [2:0]       hist;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    cnt_nxt;
  logic [IW-1:0]    idx;
  logic             armed;
  logic             last_s;
  logic             v1, v2, m1, m2;
  logic             wrap, fall, early, late;
  logic             start_pass;
  logic             vote;

  always_comb begin
    wrap    = (cnt == P_LAST);
    cnt_nxt = wrap ? P_ONE : cnt + P_ONE;
    fall    = armed && last_s && !line;
    early   = fall && (cnt_nxt >= P_EARLY) && !wrap;
    late    = fall && (cnt_nxt <= P_V3);
    start_pass = !maj3(v1, v2, line);
    vote    = maj3(m1, m2, line);
  end

  always_comb begin
    start_ok    = tick && (state == RX_START) && (cnt_nxt == P_V3) && start_pass;
    start_noise = v1 | v2 | line;
    bit_stb     = tick && (state == RX_DATA) && (cnt_nxt == P_M3);
    stop_stb    = tick && (state == RX_STOP) && (cnt_nxt == P_M3);
    bit_val     = vote;
    stop_val    = vote;
    bit_noise   = !agree3(m1, m2, line);
    stop_noise  = !agree3(m1, m2, line);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RX_IDLE;
      hist   <= 3'b000;
      cnt    <= '0;
      idx    <= '0;
      armed  <= 1'b0;
      last_s <= 1'b1;
      v1     <= 1'b0;
      v2     <= 1'b0;
      m1     <= 1'b0;
      m2     <= 1'b0;
    end else if (tick) begin
      last_s <= line;
      unique case (state)
        RX_IDLE: begin
          hist <= {hist[1:0], line};
          if (hist == 3'b111 && !line) begin
            state <= RX_START;
            cnt   <= P_ONE;
          end
        end
        RX_START: begin
          cnt <= cnt_nxt;
          if (cnt_nxt == P_V1) v1 <= line;
          if (cnt_nxt == P_V2) v2 <= line;
          if (cnt_nxt == P_V3 && !start_pass) begin
            state <= RX_IDLE;
            hist  <= 3'b000;
            cnt   <= '0;
          end else if (wrap) begin
            state <= RX_DATA;
            idx   <= '0;
            armed <= 1'b0;
          end
        end
        RX_DATA, RX_STOP: begin
          if (cnt_nxt == P_M1) m1 <= line;
          if (cnt_nxt == P_M2) m2 <= line;
          cnt <= (early || late) ? P_ONE : cnt_nxt;
          if (early || late || cnt_nxt == P_M1) armed <= 1'b0;
          if (state == RX_DATA && cnt_nxt == P_M3) armed <= vote;
          if (state == RX_STOP && cnt_nxt == P_M3) begin
            state <= RX_IDLE;
            hist  <= {m1, m2, line};
            cnt   <= '0;
            armed <= 1'b0;
          end else if (state == RX_DATA && (wrap || early)) begin
            if (idx == IDX_LAST) state <= RX_STOP;
            else                 idx   <= idx + IW'(1);
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign cnt_o   = cnt;
  assign state_o = state;
endmodule

// File: rtl/rx_frame_store.sv
module rx_frame_store #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_ok,
  input  logic                 start_noise,
  input  logic                 bit_stb,
  input  logic                 bit_val,
  input  logic                 bit_noise,
  input  logic                 stop_stb,
  input  logic                 stop_val,
  input  logic                 stop_noise,
  input  logic                 clr,
  output logic [DATA_BITS-1:0] data,
  output logic                 full,
  output logic                 noise,
  output logic                 ferr
);
  logic [DATA_BITS-1:0] shreg;
  logic                 noise_acc;
  logic                 base_full, base_noise, base_ferr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      noise_acc <= 1'b0;
    end else if (start_ok) begin
      noise_acc <= start_noise;
    end else if (bit_stb) begin
      shreg     <= {bit_val, shreg[DATA_BITS-1:1]};
      noise_acc <= noise_acc | bit_noise;
    end
  end

  always_comb begin
    base_full  = clr ? 1'b0 : full;
    base_noise = clr ? 1'b0 : noise;
    base_ferr  = clr ? 1'b0 : ferr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      full  <= 1'b0;
      noise <= 1'b0;
      ferr  <= 1'b0;
    end else if (stop_stb) begin
      data  <= shreg;
      full  <= 1'b1;
      noise <= base_noise | noise_acc | stop_noise;
      ferr  <= base_ferr | !stop_val;
    end else begin
      full  <= base_full;
      noise <= base_noise;
      ferr  <= base_ferr;
    end
  end
endmodule

// File: rtl/serial_rx_recover.sv
module serial_rx_recover #(
  parameter int OSR         = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rt_tick,
  input  logic                 rxd,
  input  logic                 flag_clr,
  input  logic                 rx_int_en,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_full,
  output logic                 rx_noise,
  output logic                 rx_frame_err,
  output logic                 rx_irq
);
  localparam int CW = $clog2(OSR + 1);

  logic          line_s;
  logic          start_ok, start_noise;
  logic          bit_stb, bit_val, bit_noise;
  logic          stop_stb, stop_val, stop_noise;
  logic [CW-1:0] samp_cnt;
  logic [1:0]    samp_state;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n(rst_n),
    .d   (rxd),
    .q   (line_s)
  );

  rx_sampler #(.OSR(OSR), .DATA_BITS(DATA_BITS)) u_samp (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (rt_tick),
    .line       (line_s),
    .start_ok   (start_ok),
    .start_noise(start_noise),
    .bit_stb    (bit_stb),
    .bit_val    (bit_val),
    .bit_noise  (bit_noise),
    .stop_stb   (stop_stb),
    .stop_val   (stop_val),
    .stop_noise (stop_noise),
    .cnt_o      (samp_cnt),
    .state_o    (samp_state)
  );

  rx_frame_store #(.DATA_BITS(DATA_BITS)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_ok   (start_ok),
    .start_noise(start_noise),
    .bit_stb    (bit_stb),
    .bit_val    (bit_val),
    .bit_noise  (bit_noise),
    .stop_stb   (stop_stb),
    .stop_val   (stop_val),
    .stop_noise (stop_noise),
    .clr        (flag_clr),
    .data       (rx_byte),
    .full       (rx_full),
    .noise      (rx_noise),
    .ferr       (rx_frame_err)
  );

  assign rx_irq = rx_full & rx_int_en;
endmodule

// File: rtl/serial_rx_recover_chk.sv
module serial_rx_recover_chk #(
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rt_tick,
  input logic                     flag_clr,
  input logic                     rx_int_en,
  input logic [DATA_BITS-1:0]     rx_byte,
  input logic                     rx_full,
  input logic                     rx_noise,
  input logic                     rx_frame_err,
  input logic                     rx_irq,
  input logic                     stop_stb,
  input logic [$clog2(OSR+1)-1:0] samp_cnt,
  input logic [1:0]               samp_state
);
  // R1
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_tick |=> ($stable(samp_cnt) && $stable(samp_state)));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_state != 2'd0) |-> (samp_cnt >= 1 && samp_cnt <= OSR));

  // R7
  ferr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_err |-> rx_full);

  // R10
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !flag_clr) |=> rx_full);

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !stop_stb) |=> (!rx_full && !rx_noise && !rx_frame_err));

  // R10
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_stb |=> $stable(rx_byte));

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_int_en |-> !rx_irq);
endmodule

bind serial_rx_recover serial_rx_recover_chk #(.OSR(OSR), .DATA_BITS(DATA_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rt_tick     (rt_tick),
  .flag_clr    (flag_clr),
  .rx_int_en   (rx_int_en),
  .rx_byte     (rx_byte),
  .rx_full     (rx_full),
  .rx_noise    (rx_noise),
  .rx_frame_err(rx_frame_err),
  .rx_irq      (rx_irq),
  .stop_stb    (stop_stb),
  .samp_cnt    (samp_cnt),
  .samp_state  (samp_state)
);

// File: tb/test_serial_rx_recover.sv
module test_serial_rx_recover;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rt_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       flag_clr = 1'b0;
  logic       rx_int_en = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_full, rx_noise, rx_frame_err, rx_irq;
  logic       tick_en = 1'b1;
  logic       done = 1'b0;
  int         checks = 0;
  int         failures = 0;

  always #2 clk = ~clk;

  serial_rx_recover i_serial_rx_recover (
    .clk(clk), .rst_n(rst_n), .rt_tick(rt_tick), .rxd(rxd),
    .flag_clr(flag_clr), .rx_int_en(rx_int_en), .rx_byte(rx_byte),
    .rx_full(rx_full), .rx_noise(rx_noise), .rx_frame_err(rx_frame_err),
    .rx_irq(rx_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one line value per tick; tick raised three clocks into the slot
  task automatic slot(input logic v);
    rxd = v;
    rt_tick = 1'b0;
    repeat (3) @(negedge clk);
    rt_tick = tick_en;
    @(negedge clk);
    rt_tick = 1'b0;
  endtask

  // bit index: 0 start, 1..8 data, 9 stop; fb/fp flip one slot each
  task automatic send_frame(input logic [7:0] d, input int blen, input logic stopv,
                            input int fb1, input int fp1, input int fb2, input int fp2,
                            input int idle);
    for (int b = 0; b < 10; b++) begin
      logic v;
      v = (b == 0) ? 1'b0 : (b == 9) ? stopv : d[b-1];
      for (int p = 1; p <= blen; p++) begin
        logic s;
        s = v;
        if ((b == fb1 && p == fp1) || (b == fb2 && p == fp2)) s = ~s;
        slot(s);
      end
    end
    for (int i = 0; i < idle; i++) slot(1'b1);
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    @(negedge clk);
  endtask

  function automatic int flips_at(input int b, input int fb1, input int fp1,
                                  input int fb2, input int fp2);
    int n = 0;
    if (fb1 == b && fp1 >= 8 && fp1 <= 10) n++;
    if (fb2 == b && fp2 >= 8 && fp2 <= 10) n++;
    return n;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [7:0] d, input int fb1, input int fp1,
                                          input int fb2, input int fp2);
    logic [7:0] r = d;
    for (int i = 0; i < 8; i++)
      if (flips_at(i + 1, fb1, fp1, fb2, fp2) >= 2) r[i] = ~r[i];
    return r;
  endfunction

  function automatic logic exp_noise(input int fb1, input int fp1, input int fb2, input int fp2);
    logic n = 1'b0;
    for (int b = 1; b < 10; b++)
      if (flips_at(b, fb1, fp1, fb2, fp2) > 0) n = 1'b1;
    if (fb1 == 0 && (fp1 == 3 || fp1 == 5 || fp1 == 7)) n = 1'b1;
    return n;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check("R13 full", rx_full, 0);
    check("R13 noise", rx_noise, 0);
    check("R13 ferr", rx_frame_err, 0);
    check("R13 byte", rx_byte, 8'h00);
    check("R13 irq", rx_irq, 0);
    for (int i = 0; i < 4; i++) slot(1'b1);

    // R1 no ticks: nothing received
    tick_en = 1'b0;
    send_frame(8'hA5, 16, 1'b1, -1, 0, -1, 0, 8);
    check("R1 no tick full", rx_full, 0);
    tick_en = 1'b1;
    for (int i = 0; i < 4; i++) slot(1'b1);

    // R2 R5 clean frame
    send_frame(8'h3C, 16, 1'b1, -1, 0, -1, 0, 8);
    check("R2 full", rx_full, 1);
    check("R5 byte", rx_byte, 8'h3C);
    check("R5 noise", rx_noise, 0);
    check("R7 ferr clean", rx_frame_err, 0);

    // R10 clear keeps byte
    pulse_clr();
    check("R10 full cleared", rx_full, 0);
    check("R10 byte held", rx_byte, 8'h3C);

    // R11 interrupt
    rx_int_en = 1'b1;
    send_frame(8'h81, 16, 1'b1, -1, 0, -1, 0, 8);
    check("R11 irq on", rx_irq, 1);
    check("R5 byte 81", rx_byte, 8'h81);
    rx_int_en = 1'b0;
    #1;
    check("R11 irq off", rx_irq, 0);
    rx_int_en = 1'b1;
    pulse_clr();
    check("R11 irq after clr", rx_irq, 0);
    rx_int_en = 1'b0;

    // R4 noisy but accepted start
    send_frame(8'hC3, 16, 1'b1, 0, 5, -1, 0, 8);
    check("R4 byte", rx_byte, 8'hC3);
    check("R4 noise", rx_noise, 1);
    pulse_clr();

    // R3 rejected start: samples at 3 and 5 high
    for (int i = 0; i < 4; i++) slot(1'b1);
    slot(0); slot(0); slot(1); slot(0); slot(1); slot(0); slot(0);
    for (int i = 0; i < 30; i++) slot(1'b1);
    check("R3 reject full", rx_full, 0);
    check("R3 reject noise", rx_noise, 0);
    send_frame(8'h5A, 16, 1'b1, -1, 0, -1, 0, 8);
    check("R3 restart byte", rx_byte, 8'h5A);
    check("R3 restart full", rx_full, 1);
    pulse_clr();

    // R6 single disagreeing sample in data bit and in stop bit
    send_frame(8'h96, 16, 1'b1, 3, 9, -1, 0, 8);
    check("R6 data byte", rx_byte, 8'h96);
    check("R6 data noise", rx_noise, 1);
    pulse_clr();
    send_frame(8'h0F, 16, 1'b1, 9, 8, -1, 0, 8);
    check("R6 stop noise", rx_noise, 1);
    check("R6 stop ferr", rx_frame_err, 0);
    pulse_clr();

    // R5 two of three samples flipped change the bit
    send_frame(8'h00, 16, 1'b1, 5, 8, 5, 10, 8);
    check("R5 majority byte", rx_byte, 8'h10);
    check("R5 majority noise", rx_noise, 1);
    pulse_clr();

    // R7 low stop bit
    send_frame(8'h6E, 16, 1'b0, -1, 0, -1, 0, 8);
    check("R7 ferr", rx_frame_err, 1);
    check("R7 full", rx_full, 1);
    check("R7 byte", rx_byte, 8'h6E);
    pulse_clr();
    check("R10 ferr cleared", rx_frame_err, 0);

    // R8 slow sender, R9 fast sender
    send_frame(8'h55, 17, 1'b1, -1, 0, -1, 0, 8);
    check("R8 byte", rx_byte, 8'h55);
    check("R8 noise", rx_noise, 0);
    check("R8 ferr", rx_frame_err, 0);
    pulse_clr();
    send_frame(8'h55, 15, 1'b1, -1, 0, -1, 0, 8);
    check("R9 byte", rx_byte, 8'h55);
    check("R9 noise", rx_noise, 0);
    check("R9 ferr", rx_frame_err, 0);
    pulse_clr();

    // R12 back-to-back frames
    send_frame(8'hE1, 16, 1'b1, -1, 0, -1, 0, 0);
    check("R12 first byte", rx_byte, 8'hE1);
    send_frame(8'h1E, 16, 1'b1, -1, 0, -1, 0, 8);
    check("R12 second byte", rx_byte, 8'h1E);
    check("R12 noise", rx_noise, 0);
    pulse_clr();

    // random frames
    void'($urandom(32'd4711));
    for (int n = 0; n < 24; n++) begin
      int mode, fb1, fp1, fb2, fp2;
      d = 8'($urandom);
      mode = int'($urandom % 3);
      fb1 = -1; fp1 = 0; fb2 = -1; fp2 = 0;
      if (mode == 1) begin
        fb1 = 1 + int'($urandom % 9);
        fp1 = 8 + int'($urandom % 3);
      end else if (mode == 2) begin
        fb1 = 1 + int'($urandom % 8);
        fp1 = 8;
        fb2 = fb1;
        fp2 = 10;
      end
      send_frame(d, 16, 1'b1, fb1, fp1, fb2, fp2, 6);
      check("R5 random byte", rx_byte, exp_byte(d, fb1, fp1, fb2, fp2));
      check("R6 random noise", rx_noise, exp_noise(fb1, fp1, fb2, fp2));
      pulse_clr();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule